// File: doc/BRIEF.md
# Core soft-reset and FIFO-flush controller

This block holds the reset-and-flush control register of a USB-style controller core. Software writes request bits into it. It can ask for a full core soft reset, a reset of the bus-side logic only, a reset of the frame counter, a flush of the receive FIFO, or a flush of one or all transmit FIFOs. For each request the block drives level control lines to the rest of the core. It clears the request bit itself when the operation ends, so software can poll the register until the bit reads back as zero.

The flush lines stay asserted for a fixed window. The bus-side reset also runs for a fixed time. The core soft reset lasts at least a minimum number of cycles and then waits for a completion handshake from the core. While the soft reset runs, every FIFO flush line is driven, any pending flush is dropped and the interrupt-enable mask is held at zero. Interrupt status and configuration state live outside this block, and the block drives nothing into them. The block also keeps a small frame counter that numbers start-of-frame events. Two read-only bits report bus-master idle and DMA-request activity.

Top module: `usb_core_rstctl`

## Requirements
- R1: Read-back layout: bit 0 soft reset pending, bit 1 bus-side reset pending, bit 2 frame reset pending, bit 4 receive flush pending, bit 5 transmit flush pending, bits 10:6 the transmit FIFO number. Bit 3 and bits 29:11 always read 0. The reset state of all of these is 0.
- R2: Bit 31 reads the `mst_idle_i` input and bit 30 reads the `dma_req_i` input, with no delay. Writes to these bits have no effect.
- R3: Writing 1 to a request bit starts its operation. Writing 0 to it never cancels an operation in progress and starts nothing.
- R4: A receive flush request drives `rxf_flush_o` and read-back bit 4 high for exactly FLUSH_CYCLES (8) cycles after the write edge. Both then drop by themselves.
- R5: A transmit flush drives `txf_flush_o` for the same FLUSH_CYCLES window. FIFO number n below NUM_TXF (0 to 15) drives line n only. The value NUM_TXF (16) drives all lines. Values 17 to 31 drive no line, but bit 5 still runs its window.
- R6: While a transmit flush is pending, writes to the FIFO number field are ignored, and both the read-back number and the selected lines stay unchanged.
- R7: A soft reset holds `core_srst_o` and bit 0 high for at least RST_MIN (4) cycles. It clears on the first edge at which that time has passed and `rst_done_i` is high. With `rst_done_i` already high, the high time is exactly RST_MIN cycles.
- R8: During a soft reset, `rxf_flush_o` and every `txf_flush_o` line are high, and `imask_o` reads 0. Writes to the mask and new flush requests are ignored. A flush that was pending when the soft reset began reads back as cleared.
- R9: A bus-side reset drives `hrst_o` and bit 1 high for exactly HRST_CYCLES (4) cycles, without asserting `core_srst_o`.
- R10: Each `sof_i` pulse sets `frame_no` to the current count and then advances the count. From reset the first frame is 0. A frame reset request keeps bit 2 high for one cycle and leaves `frame_no` unchanged until the next `sof_i`. That next `sof_i` reports frame 0, and numbering counts up from there.
- R11: Outside a soft reset, `imask_wr` loads `imask_wdata` into `imask_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read-back |
| mst_idle_i | input | 1 | Bus master state machine idle |
| dma_req_i | input | 1 | DMA request in progress |
| rst_done_i | input | 1 | Core reports soft-reset activity finished |
| imask_wr | input | 1 | Write strobe for the interrupt-enable mask |
| imask_wdata | input | IMASK_W | Interrupt-enable mask write data |
| imask_o | output | IMASK_W | Interrupt-enable mask |
| sof_i | input | 1 | Start-of-frame event |
| frame_no | output | FRAME_W | Frame number of the latest start-of-frame |
| core_srst_o | output | 1 | Core soft reset active |
| hrst_o | output | 1 | Bus-side-only reset active |
| rxf_flush_o | output | 1 | Receive FIFO flush |
| txf_flush_o | output | NUM_TXF | Per-FIFO transmit flush lines |

## Verification
The bench builds the block with its default parameters: 16 transmit FIFOs, a 5-bit selector, an 8-cycle flush window, and 4-cycle minimum soft-reset and bus-reset times. With these values every selector code is within reach. That covers the first and last single-FIFO codes, the all-FIFO code and the out-of-range codes above it. The complete flush and reset windows are short enough to be checked edge by edge, both at their last high cycle and at their first low cycle. The 11-bit frame counter never wraps in the bench. Only its reset-to-zero and count-up behaviour are exercised.

// File: rtl/usb_core_rstctl.sv
module usb_core_rstctl #(
  parameter int NUM_TXF      = 16,
  parameter int FNUM_W       = 5,
  parameter int FLUSH_CYCLES = 8,
  parameter int RST_MIN      = 4,
  parameter int HRST_CYCLES  = 4,
  parameter int IMASK_W      = 32,
  parameter int FRAME_W      = 11
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic               mst_idle_i,
  input  logic               dma_req_i,
  input  logic               rst_done_i,
  input  logic               imask_wr,
  input  logic [IMASK_W-1:0] imask_wdata,
  output logic [IMASK_W-1:0] imask_o,
  input  logic               sof_i,
  output logic [FRAME_W-1:0] frame_no,
  output logic               core_srst_o,
  output logic               hrst_o,
  output logic               rxf_flush_o,
  output logic [NUM_TXF-1:0] txf_flush_o
);
  localparam int FCW = $clog2(FLUSH_CYCLES + 1);
  localparam int SCW = $clog2(RST_MIN + 1);
  localparam int HCW = $clog2(HRST_CYCLES + 1);

  logic               s_pend, h_pend, f_pend, rx_pend, tx_pend;
  logic [SCW-1:0]     s_cnt;
  logic [HCW-1:0]     h_cnt;
  logic [FCW-1:0]     rx_cnt, tx_cnt;
  logic [FNUM_W-1:0]  fnum;
  logic [FRAME_W-1:0] fcnt;
  logic [NUM_TXF-1:0] tx_sel;

  wire req_s  = wr_en & wr_data[0];
  wire req_h  = wr_en & wr_data[1];
  wire req_f  = wr_en & wr_data[2];
  wire req_rx = wr_en & wr_data[4];
  wire req_tx = wr_en & wr_data[5];
  wire kill   = s_pend | req_s;
  wire unused_bits = ^{wr_data[31:11], wr_data[3]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_pend <= 1'b0;
      s_cnt  <= '0;
    end else if (!s_pend) begin
      if (req_s) begin
        s_pend <= 1'b1;
        s_cnt  <= SCW'(RST_MIN - 1);
      end
    end else if (s_cnt != '0)
      s_cnt <= s_cnt - 1'b1;
    else if (rst_done_i)
      s_pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_pend <= 1'b0;
      h_cnt  <= '0;
    end else if (!h_pend) begin
      if (req_h) begin
        h_pend <= 1'b1;
        h_cnt  <= HCW'(HRST_CYCLES - 1);
      end
    end else if (h_cnt != '0)
      h_cnt <= h_cnt - 1'b1;
    else
      h_pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_pend <= 1'b0;
      rx_cnt  <= '0;
    end else if (kill)
      rx_pend <= 1'b0;
    else if (!rx_pend) begin
      if (req_rx) begin
        rx_pend <= 1'b1;
        rx_cnt  <= FCW'(FLUSH_CYCLES - 1);
      end
    end else if (rx_cnt != '0)
      rx_cnt <= rx_cnt - 1'b1;
    else
      rx_pend <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_pend <= 1'b0;
      tx_cnt  <= '0;
      fnum    <= '0;
    end else begin
      if (wr_en && !tx_pend) fnum <= wr_data[6 +: FNUM_W];
      if (kill)
        tx_pend <= 1'b0;
      else if (!tx_pend) begin
        if (req_tx) begin
          tx_pend <= 1'b1;
          tx_cnt  <= FCW'(FLUSH_CYCLES - 1);
        end
      end else if (tx_cnt != '0)
        tx_cnt <= tx_cnt - 1'b1;
      else
        tx_pend <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_pend   <= 1'b0;
      fcnt     <= '0;
      frame_no <= '0;
    end else begin
      f_pend <= req_f;
      if (sof_i) begin
        frame_no <= f_pend ? '0 : fcnt;
        fcnt     <= (f_pend ? '0 : fcnt) + FRAME_W'(1);
      end else if (f_pend)
        fcnt <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       imask_o <= '0;
    else if (kill)    imask_o <= '0;
    else if (imask_wr) imask_o <= imask_wdata;

  assign tx_sel = (fnum == FNUM_W'(NUM_TXF)) ? '1 : (NUM_TXF'(1) << fnum);

  assign core_srst_o = s_pend;
  assign hrst_o      = h_pend;
  assign rxf_flush_o = s_pend | rx_pend;
  assign txf_flush_o = s_pend ? '1 : (tx_pend ? tx_sel : '0);

  always_comb begin
    rd_data              = '0;
    rd_data[0]           = s_pend;
    rd_data[1]           = h_pend;
    rd_data[2]           = f_pend;
    rd_data[4]           = rx_pend;
    rd_data[5]           = tx_pend;
    rd_data[6 +: FNUM_W] = fnum;
    rd_data[30]          = dma_req_i;
    rd_data[31]          = mst_idle_i;
  end
endmodule

// File: rtl/usb_core_rstctl_chk.sv
module usb_core_rstctl_chk #(
  parameter int NUM_TXF      = 16,
  parameter int FLUSH_CYCLES = 8,
  parameter int IMASK_W      = 32,
  parameter int FRAME_W      = 11
)(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic               rst_done_i,
  input logic               sof_i,
  input logic               core_srst_o,
  input logic               rxf_flush_o,
  input logic [NUM_TXF-1:0] txf_flush_o,
  input logic [IMASK_W-1:0] imask_o,
  input logic [FRAME_W-1:0] frame_no
);
  int rx_len;
  wire unused_chk = ^{wr_data, rd_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_len <= 0;
    else        rx_len <= rd_data[4] ? rx_len + 1 : 0;

  // R4
  rx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[4]) && !core_srst_o |-> rx_len == FLUSH_CYCLES);

  // R5
  txf_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(txf_flush_o) || (&txf_flush_o));

  // R6
  fnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] && $past(rd_data[5]) |-> $stable(rd_data[10:6]));

  // R7
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst_o && !rst_done_i |=> core_srst_o);

  // R8
  srst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst_o |-> (imask_o == '0) && rxf_flush_o && (&txf_flush_o) && !rd_data[4] && !rd_data[5]);

  // R10
  frm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] && !(wr_en && wr_data[2]) |=> !rd_data[2]);

  // R10
  frm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] && sof_i |=> frame_no == '0);
endmodule

bind usb_core_rstctl usb_core_rstctl_chk #(
  .NUM_TXF(NUM_TXF), .FLUSH_CYCLES(FLUSH_CYCLES), .IMASK_W(IMASK_W), .FRAME_W(FRAME_W)
) u_chk (.*);

// File: tb/usb_core_rstctl_tb.sv
`timescale 1ns/1ps
module usb_core_rstctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mst_idle_i = 1'b1;
  logic        dma_req_i = 1'b0;
  logic        rst_done_i = 1'b0;
  logic        imask_wr = 1'b0;
  logic [31:0] imask_wdata = '0;
  logic [31:0] imask_o;
  logic        sof_i = 1'b0;
  logic [10:0] frame_no;
  logic        core_srst_o, hrst_o, rxf_flush_o;
  logic [15:0] txf_flush_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usb_core_rstctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mst_idle_i(mst_idle_i), .dma_req_i(dma_req_i), .rst_done_i(rst_done_i),
    .imask_wr(imask_wr), .imask_wdata(imask_wdata), .imask_o(imask_o),
    .sof_i(sof_i), .frame_no(frame_no), .core_srst_o(core_srst_o), .hrst_o(hrst_o),
    .rxf_flush_o(rxf_flush_o), .txf_flush_o(txf_flush_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic imw(input logic [31:0] d);
    @(negedge clk); imask_wr = 1'b1; imask_wdata = d;
    @(negedge clk); imask_wr = 1'b0;
  endtask

  task automatic sof();
    @(negedge clk); sof_i = 1'b1;
    @(negedge clk); sof_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset bits", rd_data & 32'h3FFF_FFFF, 32'h0);
    chk("R1 reset outs", {core_srst_o, hrst_o, rxf_flush_o, txf_flush_o}, 32'h0);
    chk("R11 reset mask", imask_o, 32'h0);
  endtask

  task automatic t_status();
    chk("R2 idle=1 dma=0", {30'h0, rd_data[31:30]}, 32'h2);
    @(negedge clk); mst_idle_i = 1'b0; dma_req_i = 1'b1; #1;
    chk("R2 idle=0 dma=1", {30'h0, rd_data[31:30]}, 32'h1);
    wr(32'h0000_0000);
    chk("R2 write ignored", {30'h0, rd_data[31:30]}, 32'h1);
    mst_idle_i = 1'b1; dma_req_i = 1'b0;
  endtask

  task automatic t_layout();
    wr(32'h3FFF_F808);
    chk("R1 unused bits zero", rd_data & 32'h3FFF_F808, 32'h0);
    chk("R3 write zero idle", rd_data & 32'h37, 32'h0);
  endtask

  task automatic t_rx();
    wr(32'h10);
    chk("R4 rx start", {rd_data[4], rxf_flush_o}, 32'h3);
    wr(32'h0);
    chk("R3 zero keeps rx", {31'h0, rd_data[4]}, 32'h1);
    step(5);
    chk("R4 rx last high", {rd_data[4], rxf_flush_o}, 32'h3);
    chk("R4 tx idle", {16'h0, txf_flush_o}, 32'h0);
    step(1);
    chk("R4 rx dropped", {rd_data[4], rxf_flush_o}, 32'h0);
  endtask

  task automatic t_tx(input logic [4:0] n, input logic [15:0] lines);
    wr({21'h0, n, 6'h20});
    chk("R5 tx num", {27'h0, rd_data[10:6]}, {27'h0, n});
    chk("R5 tx pend", {31'h0, rd_data[5]}, 32'h1);
    chk("R5 tx lines", {16'h0, txf_flush_o}, {16'h0, lines});
    wr({21'h0, 5'd7, 6'h20});
    chk("R6 num held", {27'h0, rd_data[10:6]}, {27'h0, n});
    chk("R6 lines held", {16'h0, txf_flush_o}, {16'h0, lines});
    step(5);
    chk("R5 tx last high", {16'h0, txf_flush_o}, {16'h0, lines});
    chk("R5 tx pend last", {31'h0, rd_data[5]}, 32'h1);
    step(1);
    chk("R5 tx dropped", {15'h0, rd_data[5], txf_flush_o}, 32'h0);
  endtask

  task automatic t_srst();
    rst_done_i = 1'b0;
    imw(32'hFFFF_FFFF);
    chk("R11 mask load", imask_o, 32'hFFFF_FFFF);
    wr(32'h30);
    wr(32'h1);
    chk("R7 srst on", {30'h0, rd_data[0], core_srst_o}, 32'h3);
    chk("R8 flush dropped", {30'h0, rd_data[5:4]}, 32'h0);
    chk("R8 all lines", {15'h0, rxf_flush_o, txf_flush_o}, 32'h1FFFF);
    chk("R8 mask cleared", imask_o, 32'h0);
    imw(32'h55);
    chk("R8 mask write ignored", imask_o, 32'h0);
    wr(32'h10);
    chk("R8 rx req ignored", {31'h0, rd_data[4]}, 32'h0);
    step(10);
    chk("R7 waits done", {31'h0, core_srst_o}, 32'h1);
    rst_done_i = 1'b1;
    step(1);
    chk("R7 srst off", {30'h0, rd_data[0], core_srst_o}, 32'h0);
    chk("R8 lines off", {15'h0, rxf_flush_o, txf_flush_o}, 32'h0);
    imw(32'h55);
    chk("R11 mask after srst", imask_o, 32'h55);
    wr(32'h1);
    step(3);
    chk("R7 min hold", {31'h0, core_srst_o}, 32'h1);
    step(1);
    chk("R7 min end", {31'h0, core_srst_o}, 32'h0);
  endtask

  task automatic t_hrst();
    wr(32'h2);
    chk("R9 hrst on", {29'h0, rd_data[1], hrst_o, core_srst_o}, 32'h6);
    step(3);
    chk("R9 hrst last", {30'h0, rd_data[1], hrst_o}, 32'h3);
    step(1);
    chk("R9 hrst off", {30'h0, rd_data[1], hrst_o}, 32'h0);
  endtask

  task automatic t_frame();
    sof(); chk("R10 frame 0", {21'h0, frame_no}, 32'd0);
    sof(); chk("R10 frame 1", {21'h0, frame_no}, 32'd1);
    sof(); chk("R10 frame 2", {21'h0, frame_no}, 32'd2);
    wr(32'h4);
    chk("R10 frst pend", {31'h0, rd_data[2]}, 32'h1);
    chk("R10 frame kept", {21'h0, frame_no}, 32'd2);
    step(1);
    chk("R10 frst clear", {31'h0, rd_data[2]}, 32'h0);
    sof(); chk("R10 frame restart", {21'h0, frame_no}, 32'd0);
    sof(); chk("R10 frame next", {21'h0, frame_no}, 32'd1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_status();
    t_layout();
    t_rx();
    t_tx(5'd3,  16'h0008);
    t_tx(5'd0,  16'h0001);
    t_tx(5'd15, 16'h8000);
    t_tx(5'd16, 16'hFFFF);
    t_tx(5'd31, 16'h0000);
    t_srst();
    t_hrst();
    t_frame();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule